// File: doc/BRIEF.md
# Three-Level Carrier PWM Modulator

This block turns three signed phase references into three-level leg states and gate drives for a neutral-point-clamped bridge. A shared triangular carrier is produced by an up/down counter that runs from zero to a programmable peak and back. Each phase reference is compared against an upper carrier, which spans the positive half of the range, and a lower carrier, which spans the negative half. A control input chooses whether the lower carrier runs in step with the upper one or mirrored against it. The result is a per-phase state of positive rail, neutral point or negative rail.

References arrive over a valid/ready stream from the neutral-point offset calculator. The block has a single holding slot. `ref_ready` is high while that slot is empty. A reference accepted into the slot stays there until the next carrier valley, when it becomes active. While the slot is full, `ref_ready` is low, so the sender must hold `ref_valid` and the data until the valley frees the slot. The duty cycle therefore never changes inside a carrier period. A one-cycle `period_start` pulse at each valley tells the upstream logic to sample and compute the next offset.

Each leg state is turned into four gate signals. Direct swings between the two rails are routed through the neutral state. Each gate turns on only after a programmable dead time and turns off at once.

Top module: `npc3_carrier_pwm`

## Requirements
- R1: Phase state codes are 2'b01 for the positive rail, 2'b00 for the neutral point and 2'b11 for the negative rail. After reset every phase is 2'b00, outer gates S1 and S4 are off, and `ref_ready` is high.
- R2: The carrier count runs 0,1,…,P,P−1,…,1 and repeats, so a period is 2P clocks. `period_start` is high only in the cycle whose count is 0. A new `carrier_peak` takes effect at a valley, and a peak of 0 acts as 1.
- R3: The state is positive when the reference exceeds the upper carrier (the count), negative when it is below the lower carrier, and neutral otherwise. A reference r with 1 ≤ r ≤ P gives 2r−1 positive cycles per period and no negative cycles; r = −k gives 2k−1 negative cycles; r = 0 gives all-neutral.
- R4: With `anti_phase` = 0 the lower carrier is count − P. With `anti_phase` = 1 it is −count. The state lags the count by one cycle, so in the cycle after `period_start` a negative reference reads 2'b00 in-phase and 2'b11 anti-phase.
- R5: References beyond ±P act as ±P, giving 2P−1 cycles on that rail.
- R6: Phase k's reference is the signed 17-bit field `ref_data[17k +: 17]`, in carrier counts. `ref_ready` falls after an accept and rises only at the next valley. The accepted value governs the state from the cycle after the next `period_start`, and not earlier.
- R7: Gate bits for leg k sit at `gate[4k +: 4]` with S1 in bit 0 through S4 in bit 3. Positive turns on S1 and S2, neutral turns on S2 and S3, and negative turns on S3 and S4. S1 and S3 are never on together, and neither are S2 and S4.
- R8: A leg never moves between 2'b01 and 2'b11 in one cycle. It spends at least one cycle at 2'b00 in between.
- R9: A gate turns on `dead_time` cycles after the state that demands it appears (at once when `dead_time` is 0). It turns off in the same cycle the state leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_valid | input | 1 | Reference triple offered |
| ref_ready | output | 1 | Holding slot empty |
| ref_data | input | 51 | Three signed 17-bit references, phase 0 in the low bits |
| carrier_peak | input | 16 | Carrier peak count P |
| anti_phase | input | 1 | 1 selects mirrored lower carrier |
| dead_time | input | 8 | Turn-on delay in clocks |
| period_start | output | 1 | High in the valley cycle |
| phase_state | output | 6 | Two-bit state per phase |
| gate | output | 12 | Four gate drives per leg |

## Verification
The hardest situation to reach is a demand to swing a leg straight from the positive rail to the negative rail. In in-phase disposition both carriers are at a bound at the valley, so such a demand never arises there. The bench therefore selects anti-phase, where the lower carrier is zero at the valley. It first holds a full-scale positive reference, then loads a full-scale negative one mid-period so that the swap lands on the valley edge. A sampling monitor then confirms that a single neutral cycle bridges the two rails and that no gate pair ever overlaps.

// File: rtl/npc3_pwm_pkg.sv
package npc3_pwm_pkg;
  typedef enum logic [1:0] {
    LVL_ZERO = 2'b00,
    LVL_POS  = 2'b01,
    LVL_NEG  = 2'b11
  } lvl_e;

  localparam int unsigned GATES_PER_LEG = 4;
endpackage

// File: rtl/npc3_carrier_gen.sv
module npc3_carrier_gen #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] peak_in,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] peak_act,
  output logic          valley_load,
  output logic          at_valley
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_nxt, peak_q, peak_safe;
  logic          up_q, up_nxt;

  assign peak_safe = (peak_in == '0) ? ONE : peak_in;

  always_comb begin
    if (up_q && (cnt_q < peak_q)) begin
      cnt_nxt = cnt_q + ONE;
      up_nxt  = 1'b1;
    end else begin
      cnt_nxt = cnt_q - ONE;
      up_nxt  = 1'b0;
    end
    if (cnt_nxt == '0) up_nxt = 1'b1;
  end

  assign valley_load = (cnt_nxt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      up_q   <= 1'b1;
      peak_q <= ONE;
    end else begin
      cnt_q <= cnt_nxt;
      up_q  <= up_nxt;
      if (valley_load) peak_q <= peak_safe;
    end
  end

  assign cnt       = cnt_q;
  assign peak_act  = peak_q;
  assign at_valley = (cnt_q == '0);

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= peak_q);
  a_r2_valley_single: assert property (@(posedge clk) disable iff (!rst_n)
    at_valley |=> (cnt_q == ONE));
  a_r2_peak_at_valley: assert property (@(posedge clk) disable iff (!rst_n)
    !at_valley |-> $stable(peak_q));
endmodule

// File: rtl/npc3_ref_stage.sv
module npc3_ref_stage #(
  parameter int unsigned DW = 51
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          load,
  output logic [DW-1:0] act_data
);
  logic [DW-1:0] pend_q, act_q;
  logic          full_q;

  assign in_ready = !full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
      full_q <= 1'b0;
    end else if (load && full_q) begin
      act_q  <= pend_q;
      full_q <= 1'b0;
    end else if (in_valid && !full_q) begin
      pend_q <= in_data;
      full_q <= 1'b1;
    end
  end

  assign act_data = act_q;

  a_r6_hold_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(act_q));
  a_r6_ready_until_valley: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !load) |=> !in_ready);
endmodule

// File: rtl/npc3_phase_cmp.sv
module npc3_phase_cmp
  import npc3_pwm_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] peak,
  input  logic          anti,
  input  logic [CW:0]   ref_raw,
  output lvl_e          tgt
);
  localparam int unsigned RW = CW + 1;

  logic signed [RW-1:0] pk_s, up_s, lo_s, r_s, r_c;

  always_comb begin
    pk_s = signed'({1'b0, peak});
    up_s = signed'({1'b0, cnt});
    r_s  = signed'(ref_raw);
    if (r_s > pk_s)       r_c = pk_s;
    else if (r_s < -pk_s) r_c = -pk_s;
    else                  r_c = r_s;
    lo_s = anti ? -up_s : (up_s - pk_s);
    if (r_c > up_s)      tgt = LVL_POS;
    else if (r_c < lo_s) tgt = LVL_NEG;
    else                 tgt = LVL_ZERO;
  end
endmodule

// File: rtl/npc3_leg_ctrl.sv
module npc3_leg_ctrl
  import npc3_pwm_pkg::*;
#(
  parameter int unsigned DTW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  lvl_e           tgt,
  input  logic [DTW-1:0] dead_time,
  output logic [1:0]     state,
  output logic [GATES_PER_LEG-1:0] gate
);
  lvl_e st_q, st_nxt;
  logic [GATES_PER_LEG-1:0] want;

  always_comb begin
    st_nxt = tgt;
    if ((st_q == LVL_POS && tgt == LVL_NEG) || (st_q == LVL_NEG && tgt == LVL_POS))
      st_nxt = LVL_ZERO;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LVL_ZERO;
    else        st_q <= st_nxt;
  end

  assign want[0] = (st_q == LVL_POS);
  assign want[1] = (st_q == LVL_POS) || (st_q == LVL_ZERO);
  assign want[2] = (st_q == LVL_ZERO) || (st_q == LVL_NEG);
  assign want[3] = (st_q == LVL_NEG);

  for (genvar g = 0; g < GATES_PER_LEG; g++) begin : g_timer
    logic [DTW-1:0] dly_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               dly_q <= '0;
      else if (!want[g])        dly_q <= '0;
      else if (dly_q < dead_time) dly_q <= dly_q + DTW'(1);
    end
    assign gate[g] = want[g] && (dly_q >= dead_time);
  end

  assign state = st_q;

  a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    state != 2'b10);
  a_r7_no_shoot_13: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate[0] && gate[2]));
  a_r7_no_shoot_24: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate[1] && gate[3]));
  a_r8_pos_not_to_neg: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'b01) |=> (state != 2'b11));
  a_r8_neg_not_to_pos: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'b11) |=> (state != 2'b01));
  a_r9_off_s1: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 2'b01) |-> !gate[0]);
  a_r9_off_s4: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 2'b11) |-> !gate[3]);
endmodule

// File: rtl/npc3_carrier_pwm.sv
module npc3_carrier_pwm
  import npc3_pwm_pkg::*;
#(
  parameter int unsigned CW  = 16,
  parameter int unsigned NPH = 3,
  parameter int unsigned DTW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ref_valid,
  output logic                 ref_ready,
  input  logic [NPH*(CW+1)-1:0] ref_data,
  input  logic [CW-1:0]        carrier_peak,
  input  logic                 anti_phase,
  input  logic [DTW-1:0]       dead_time,
  output logic                 period_start,
  output logic [2*NPH-1:0]     phase_state,
  output logic [GATES_PER_LEG*NPH-1:0] gate
);
  localparam int unsigned RW = CW + 1;
  localparam int unsigned DW = NPH * RW;

  logic [CW-1:0] cnt, peak_act;
  logic          valley_load, at_valley;
  logic [DW-1:0] act_data;

  npc3_carrier_gen #(.CW(CW)) u_car (
    .clk(clk), .rst_n(rst_n), .peak_in(carrier_peak),
    .cnt(cnt), .peak_act(peak_act),
    .valley_load(valley_load), .at_valley(at_valley)
  );

  npc3_ref_stage #(.DW(DW)) u_ref (
    .clk(clk), .rst_n(rst_n),
    .in_valid(ref_valid), .in_ready(ref_ready), .in_data(ref_data),
    .load(valley_load), .act_data(act_data)
  );

  for (genvar k = 0; k < NPH; k++) begin : g_phase
    lvl_e tgt;
    npc3_phase_cmp #(.CW(CW)) u_cmp (
      .cnt(cnt), .peak(peak_act), .anti(anti_phase),
      .ref_raw(act_data[k*RW +: RW]), .tgt(tgt)
    );
    npc3_leg_ctrl #(.DTW(DTW)) u_leg (
      .clk(clk), .rst_n(rst_n), .tgt(tgt), .dead_time(dead_time),
      .state(phase_state[2*k +: 2]),
      .gate(gate[GATES_PER_LEG*k +: GATES_PER_LEG])
    );
  end

  assign period_start = at_valley;
endmodule

// File: tb/sim_npc3_carrier_pwm.sv
module sim_npc3_carrier_pwm;
  localparam int CLK_NS = 10;
  localparam int P = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_valid = 1'b0;
  logic        ref_ready;
  logic [50:0] ref_data = '0;
  logic [15:0] carrier_peak = 16'(P);
  logic        anti_phase = 1'b0;
  logic [7:0]  dead_time = 8'd3;
  logic        period_start;
  logic [5:0]  phase_state;
  logic [11:0] gate;

  int n_chk = 0, n_bad = 0;
  int direct_err = 0, bridge_seen = 0, shoot_err = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  npc3_carrier_pwm u0 (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_ready(ref_ready),
    .ref_data(ref_data), .carrier_peak(carrier_peak), .anti_phase(anti_phase),
    .dead_time(dead_time), .period_start(period_start),
    .phase_state(phase_state), .gate(gate)
  );

  logic [1:0] pa1 = 2'b00, pa2 = 2'b00;
  always @(negedge clk) if (rst_n) begin
    if (pa1 == 2'b01 && phase_state[1:0] == 2'b11) direct_err++;
    if (pa2 == 2'b01 && pa1 == 2'b00 && phase_state[1:0] == 2'b11) bridge_seen++;
    pa2 <= pa1;
    pa1 <= phase_state[1:0];
    for (int k = 0; k < 3; k++)
      if ((gate[4*k] && gate[4*k+2]) || (gate[4*k+1] && gate[4*k+3])) shoot_err++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic wait_ps();
    do @(negedge clk); while (!period_start);
  endtask

  task automatic send_ref(input int a, input int b, input int c);
    ref_data = {17'(c), 17'(b), 17'(a)};
    ref_valid = 1'b1;
    forever begin
      if (ref_ready) begin
        @(negedge clk);
        ref_valid = 1'b0;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic apply(input int a, input int b, input int c);
    send_ref(a, b, c);
    wait_ps();
    wait_ps();
  endtask

  task automatic count_window(input int ph, output int npos, output int nneg);
    npos = 0; nneg = 0;
    wait_ps();
    for (int i = 0; i < 2*P; i++) begin
      @(negedge clk);
      if (phase_state[2*ph +: 2] == 2'b01) npos++;
      if (phase_state[2*ph +: 2] == 2'b11) nneg++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(phase_state == 6'b0, "R1 reset state", int'(phase_state), 0);
    chk((gate & 12'h999) == 12'h0, "R1 outer gates off", int'(gate & 12'h999), 0);
    chk(ref_ready == 1'b1, "R1 ready after reset", int'(ref_ready), 1);
  endtask

  task automatic t_duty(input bit anti);
    int p, n;
    anti_phase = anti;
    apply(7, -5, 0);
    count_window(0, p, n);
    chk(p == 13 && n == 0, "R3 positive duty", p, 13);
    count_window(1, p, n);
    chk(n == 9 && p == 0, "R3 negative duty", n, 9);
    count_window(2, p, n);
    chk(p == 0 && n == 0, "R3 zero reference", p + n, 0);
  endtask

  task automatic t_disp();
    anti_phase = 1'b0;
    wait_ps(); wait_ps();
    @(negedge clk);
    chk(phase_state[3:2] == 2'b00, "R4 in-phase at valley", int'(phase_state[3:2]), 0);
    anti_phase = 1'b1;
    wait_ps(); wait_ps();
    @(negedge clk);
    chk(phase_state[3:2] == 2'b11, "R4 anti-phase at valley", int'(phase_state[3:2]), 3);
  endtask

  task automatic t_clamp();
    int p, n;
    anti_phase = 1'b0;
    apply(30, -30, 20);
    count_window(0, p, n);
    chk(p == 2*P-1, "R5 clamp positive", p, 2*P-1);
    count_window(1, p, n);
    chk(n == 2*P-1, "R5 clamp negative in-phase", n, 2*P-1);
    count_window(2, p, n);
    chk(p == 2*P-1, "R5 at full scale", p, 2*P-1);
    anti_phase = 1'b1;
    wait_ps();
    count_window(1, p, n);
    chk(n == 2*P-1, "R5 clamp negative anti-phase", n, 2*P-1);
  endtask

  task automatic t_latch();
    int p = 0, n;
    anti_phase = 1'b0;
    apply(7, -5, 0);
    wait_ps();
    for (int i = 0; i < 2*P; i++) begin
      @(negedge clk);
      if (phase_state[1:0] == 2'b01) p++;
      if (i == P/2) begin
        chk(ref_ready == 1'b1, "R6 ready with empty slot", int'(ref_ready), 1);
        ref_data = {17'(0), 17'(-5), 17'(3)};
        ref_valid = 1'b1;
      end
      if (i == P/2 + 1) begin
        ref_valid = 1'b0;
        chk(ref_ready == 1'b0, "R6 ready low while held", int'(ref_ready), 0);
      end
    end
    chk(p == 13, "R6 no change inside period", p, 13);
    count_window(0, p, n);
    chk(p == 5, "R6 new reference after valley", p, 5);
    chk(ref_ready == 1'b1, "R6 ready after valley", int'(ref_ready), 1);
  endtask

  task automatic t_bridge();
    anti_phase = 1'b1;
    apply(P, 0, 0);
    direct_err = 0; bridge_seen = 0;
    send_ref(-P, 0, 0);
    wait_ps(); wait_ps(); wait_ps();
    chk(direct_err == 0, "R8 no direct rail swap", direct_err, 0);
    chk(bridge_seen > 0, "R8 neutral bridge seen", bridge_seen, 1);
  endtask

  task automatic t_gates();
    anti_phase = 1'b0;
    apply(P, -P, 0);
    wait_ps();
    repeat (P/2) @(negedge clk);
    chk(gate == 12'h6C3, "R7 gate mapping", int'(gate), 'h6C3);
    chk(shoot_err == 0, "R7 no overlapping gates", shoot_err, 0);
  endtask

  task automatic t_dead(input int dt);
    logic [1:0] prev;
    int gap = -1;
    anti_phase = 1'b0;
    dead_time = 8'(dt);
    apply(7, 0, 0);
    wait_ps();
    prev = phase_state[1:0];
    for (int i = 0; i < 2*P; i++) begin
      @(negedge clk);
      if (prev == 2'b01 && phase_state[1:0] == 2'b00) begin
        chk(gate[0] == 1'b0, "R9 turn-off immediate", int'(gate[0]), 0);
        gap = 0;
        while (!gate[2] && gap < 2*P) begin
          @(negedge clk);
          gap++;
        end
        break;
      end
      prev = phase_state[1:0];
    end
    chk(gap == dt, "R9 turn-on delay", gap, dt);
  endtask

  task automatic t_period();
    int span;
    int pk[3] = '{P, 10, 0};
    int ex[3] = '{2*P, 20, 2};
    for (int j = 0; j < 3; j++) begin
      carrier_peak = 16'(pk[j]);
      wait_ps(); wait_ps();
      span = 0;
      do begin @(negedge clk); span++; end while (!period_start);
      chk(span == ex[j], "R2 carrier period", span, ex[j]);
    end
    carrier_peak = 16'(P);
    wait_ps(); wait_ps();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_period();
    t_duty(1'b0);
    t_duty(1'b1);
    t_disp();
    t_clamp();
    t_latch();
    t_gates();
    t_bridge();
    t_dead(3);
    t_dead(0);
    chk(shoot_err == 0, "R7 overlap over whole run", shoot_err, 0);
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    report();
  end
endmodule